// File: doc/BRIEF.md
# Banked Configuration Index/Data Port

This block is a two-byte host window onto a configuration register space. The host first writes a register number into the index byte of the window. It then reads or writes the data byte, and that access goes to whichever register the index points at. Chip-wide registers (a fixed identity byte, a revision byte and a device-select byte) are visible at all times. Three further indices reach a bank of registers that belongs to the logical device currently selected: one activation bit and a 16-bit I/O base address. Every logical device has its own bank, so selecting another device swaps in a different set of these registers.

A strap input places the window at one of two I/O bases. Strap low gives index at 0x2E and data at 0x2F. Strap high gives 0x4E and 0x4F. Device 0x0E is the temperature-monitor function. All banks drive their activation flag and base address straight to output ports, so the rest of the chip can decode each function's own I/O range.

The host side is a simple byte bus with a read strobe and a write strobe. A small controller with two states handles it. ST_IDLE is the state with no read response pending. ST_RESP presents read data for one cycle. The transition IDLE→RESP (or RESP→RESP) is taken on a read that hits the window, and RESP→IDLE (or IDLE→IDLE) on any cycle without one.

Top module: `cfg_index_port`

## Requirements
- R1: With `strap_alt`=0 the index byte is at 0x2E and the data byte at 0x2F. With `strap_alt`=1 they are at 0x4E and 0x4F. Accesses to any other address cause no register change and no read response.
- R2: A read of the index byte returns the last value written to it.
- R3: Index 0x20 reads 0xE9. Writes to it are ignored.
- R4: Index 0x27 reads the REVISION parameter (default 0x03). Writes to it are ignored.
- R5: Index 0x07 is the logical-device select. It is readable and writable.
- R6: Index 0x30 bit 0 is the selected device's activation bit. It reads back as {7'b0, bit} and drives `dev_active[device]`.
- R7: Index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of the selected device's base address, which drives `dev_base[16*device +: 16]`.
- R8: Each device's activation bit and base address persist while other devices are selected and written.
- R9: Reads of unimplemented indices return 0x00 and writes to them are ignored. When the select value is NUM_DEV or above, reads of 0x30, 0x60 and 0x61 return 0x00 and writes to them change nothing.
- R10: A read strobe that hits the window at a clock edge gives `bus_rvalid`=1 with the data for exactly the following cycle. `bus_rdata` is 0x00 whenever `bus_rvalid` is 0. If read and write strobes come together, only the write is performed.
- R11: Reset clears the index, the select, all activation bits and all base addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Window base select: 0 for 0x2E, 1 for 0x4E |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response present |
| dev_active | output | NUM_DEV | Activation flag of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device |

## Verification
The bench selects a device, programs it, then switches to another device. This catches a design with one shared bank, which would read back the first device's values through the second, and it checks that the first bank still holds its values after the switch. It writes to the identity register and to an unused index and then reads both. A design that let those writes land would return the written byte in place of 0xE9 or 0x00. It selects a device number past the last bank. A design that truncated the select would alias onto a low-numbered device and set its activation output. It repeats the strap test at the other base and accesses the base that is not selected. A decoder that ignored the strap would answer there and corrupt the index.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam logic [7:0] IDX_LDSEL  = 8'h07;
    localparam logic [7:0] IDX_CHIPID = 8'h20;
    localparam logic [7:0] IDX_REV    = 8'h27;
    localparam logic [7:0] IDX_ACTV   = 8'h30;
    localparam logic [7:0] IDX_BASEHI = 8'h60;
    localparam logic [7:0] IDX_BASELO = 8'h61;
    localparam logic [7:0] CHIP_ID    = 8'hE9;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } cfgp_state_t;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE_A = 16'h002E,
    parameter logic [15:0] BASE_B = 16'h004E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_idx,
    output logic              hit_dat
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_A);
    localparam logic [ADDR_W-1:0] IDX_B = ADDR_W'(BASE_B);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_A + 16'd1);
    localparam logic [ADDR_W-1:0] DAT_B = ADDR_W'(BASE_B + 16'd1);

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;

    always_comb begin
        idx_addr = strap_alt ? IDX_B : IDX_A;
        dat_addr = strap_alt ? DAT_B : DAT_A;
        hit_idx  = (addr == idx_addr);
        hit_dat  = (addr == dat_addr);
    end

    // R1: at most one window byte is decoded at a time
    a_r1_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_idx, hit_dat}));
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank #(
    parameter int DATA_W = 8,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_ctl,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic              active,
    output logic [BASE_W-1:0] base
);
    localparam int LO_W = BASE_W - DATA_W;

    logic              act_q;
    logic [DATA_W-1:0] hi_q;
    logic [LO_W-1:0]   lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (we_ctl) act_q <= wdata[0];
            if (we_hi)  hi_q  <= wdata;
            if (we_lo)  lo_q  <= LO_W'(wdata);
        end
    end

    always_comb begin
        active = act_q;
        base   = {hi_q, lo_q};
    end

    // R8: a bank changes only when its own registers are written
    a_r8_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_ctl) |-> $stable(active));
    a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_hi) && !$past(we_lo) |-> $stable(base));
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic              hit_idx,
    input  logic              hit_dat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dat_value,
    output logic [DATA_W-1:0] index_q,
    output logic [DATA_W-1:0] sel_q,
    output logic              dat_we,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    cfgp_state_t       state_q;
    cfgp_state_t       state_d;
    logic              rd_hit;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_value;

    always_comb begin
        rd_hit   = rd && !wr && (hit_idx || hit_dat);
        dat_we   = wr && hit_dat;
        rd_value = hit_idx ? index_q : dat_value;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_hit ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_hit ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            index_q <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_hit ? rd_value : '0;
            if (wr && hit_idx) index_q <= wdata;
            if (dat_we && index_q == IDX_LDSEL) sel_q <= wdata;
        end
    end

    always_comb begin
        rvalid = (state_q == ST_RESP);
        rdata  = rdata_q;
    end

    // R10: a response follows only a window read made without a write
    a_r10_resp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd && !wr && (hit_idx || hit_dat)));
    a_r10_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);
    // R5: select changes only through a data write
    a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr && hit_dat) |-> $stable(sel_q));
    // R2: index changes only through an index write
    a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr && hit_idx) |-> $stable(index_q));
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgp_pkg::*;
#(
    parameter int         NUM_DEV  = 16,
    parameter int         ADDR_W   = 16,
    parameter int         DATA_W   = 8,
    parameter int         BASE_W   = 16,
    parameter logic [7:0] REVISION = 8'h03
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_alt,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_rvalid,
    output logic [NUM_DEV-1:0]        dev_active,
    output logic [NUM_DEV*BASE_W-1:0] dev_base
);
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int LO_W  = BASE_W - DATA_W;

    logic              hit_idx;
    logic              hit_dat;
    logic [DATA_W-1:0] index_q;
    logic [DATA_W-1:0] sel_q;
    logic              dat_we;
    logic [DATA_W-1:0] dat_value;
    logic              sel_ok;
    logic [DEV_W-1:0]  sel_dev;
    logic              wr_ctl;
    logic              wr_hi;
    logic              wr_lo;
    logic [BASE_W-1:0] base_arr [NUM_DEV];

    cfgp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .addr      (bus_addr),
        .hit_idx   (hit_idx),
        .hit_dat   (hit_dat)
    );

    cfgp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .hit_idx   (hit_idx),
        .hit_dat   (hit_dat),
        .wdata     (bus_wdata),
        .dat_value (dat_value),
        .index_q   (index_q),
        .sel_q     (sel_q),
        .dat_we    (dat_we),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    always_comb begin
        sel_ok  = (int'(sel_q) < NUM_DEV);
        sel_dev = DEV_W'(sel_q);
        wr_ctl  = dat_we && sel_ok && (index_q == IDX_ACTV);
        wr_hi   = dat_we && sel_ok && (index_q == IDX_BASEHI);
        wr_lo   = dat_we && sel_ok && (index_q == IDX_BASELO);
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        logic here;
        assign here = (int'(sel_dev) == g);
        cfgp_bank #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_ctl (wr_ctl && here),
            .we_hi  (wr_hi && here),
            .we_lo  (wr_lo && here),
            .wdata  (bus_wdata),
            .active (dev_active[g]),
            .base   (base_arr[g])
        );
        assign dev_base[g*BASE_W +: BASE_W] = base_arr[g];
    end

    always_comb begin
        dat_value = '0;
        case (index_q)
            IDX_LDSEL:  dat_value = sel_q;
            IDX_CHIPID: dat_value = CHIP_ID;
            IDX_REV:    dat_value = REVISION;
            IDX_ACTV:   if (sel_ok) dat_value = {{(DATA_W-1){1'b0}}, dev_active[sel_dev]};
            IDX_BASEHI: if (sel_ok) dat_value = base_arr[sel_dev][BASE_W-1:LO_W];
            IDX_BASELO: if (sel_ok) dat_value = DATA_W'(base_arr[sel_dev][LO_W-1:0]);
            default:    dat_value = '0;
        endcase
    end

    // R9: an out-of-range select never reaches a bank
    a_r9_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |=> $stable(dev_active));
endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 36;
    localparam logic [7:0] EXP_REV = 8'h03;

    // vector: op[1:0] (0 write, 1 read+expect, 2 read expect no response), addr, data
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 16'h002E, 8'h07},  // R2 set index
        {2'd1, 16'h002E, 8'h07},  // R2 index readback
        {2'd0, 16'h002F, 8'h0E},  // R5 select temperature device
        {2'd1, 16'h002F, 8'h0E},  // R5 select readback
        {2'd0, 16'h002E, 8'h30},
        {2'd0, 16'h002F, 8'hFF},  // R6 only bit 0 kept
        {2'd1, 16'h002F, 8'h01},  // R6
        {2'd0, 16'h002E, 8'h60},
        {2'd0, 16'h002F, 8'h12},  // R7 high byte
        {2'd0, 16'h002E, 8'h61},
        {2'd0, 16'h002F, 8'h34},  // R7 low byte
        {2'd1, 16'h002F, 8'h34},  // R7
        {2'd0, 16'h002E, 8'h60},
        {2'd1, 16'h002F, 8'h12},  // R7
        {2'd0, 16'h002E, 8'h20},
        {2'd1, 16'h002F, 8'hE9},  // R3 identity
        {2'd0, 16'h002F, 8'h55},
        {2'd1, 16'h002F, 8'hE9},  // R3 write ignored
        {2'd0, 16'h002E, 8'h27},
        {2'd0, 16'h002F, 8'hAA},
        {2'd1, 16'h002F, EXP_REV},// R4 revision, write ignored
        {2'd0, 16'h002E, 8'h07},
        {2'd0, 16'h002F, 8'h03},  // R8 switch to device 3
        {2'd0, 16'h002E, 8'h30},
        {2'd1, 16'h002F, 8'h00},  // R8 device 3 bank separate
        {2'd0, 16'h002E, 8'h61},
        {2'd0, 16'h002F, 8'h99},  // R8 program device 3
        {2'd0, 16'h002E, 8'h07},
        {2'd0, 16'h002F, 8'h0E},
        {2'd0, 16'h002E, 8'h61},
        {2'd1, 16'h002F, 8'h34},  // R8 device 14 kept its value
        {2'd0, 16'h002E, 8'h45},
        {2'd0, 16'h002F, 8'h77},
        {2'd1, 16'h002F, 8'h00},  // R9 unimplemented index
        {2'd2, 16'h004F, 8'h00},  // R1 alternate base silent under strap 0
        {2'd1, 16'h002E, 8'h45}   // R2/R1 index untouched
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap_alt = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_rdata;
    logic         bus_rvalid;
    logic [15:0]  dev_active;
    logic [255:0] dev_base;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port u_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .dev_active(dev_active), .dev_base(dev_base)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic v, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rvalid; d = bus_rdata;
    endtask

    initial begin
        logic v;
        logic [7:0] d;
        logic [255:0] exp_base;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 active", 256'(dev_active), 256'(0));
        check("R11 base", dev_base, '0);
        check("R10 idle", 256'({bus_rvalid, bus_rdata}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(16'h002E, v, d);
        check("R11 index", 256'({v, d}), 256'({1'b1, 8'h00}));

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [15:0] a;
            logic [7:0]  x;
            {op, a, x} = VEC[i];
            if (op == 2'd0) bus_write(a, x);
            else begin
                bus_read(a, v, d);
                if (op == 2'd1) check($sformatf("vector %0d", i), 256'({v, d}), 256'({1'b1, x}));
                else check($sformatf("R1 vector %0d", i), 256'({v, d}), 256'(0));
            end
        end

        // R6 R7 output ports
        check("R6 dev_active", 256'(dev_active), 256'(16'h4000));
        exp_base = '0;
        exp_base[14*16 +: 16] = 16'h1234;
        exp_base[3*16 +: 16]  = 16'h0099;
        check("R7 dev_base", dev_base, exp_base);

        // R10 response is a single cycle; simultaneous strobes perform write only
        @(negedge clk);
        check("R10 single pulse", 256'({bus_rvalid, bus_rdata}), 256'(0));
        bus_addr = 16'h002E; bus_wdata = 8'h27; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R10 write wins", 256'(bus_rvalid), 256'(0));
        bus_read(16'h002F, v, d);
        check("R10 write applied", 256'({v, d}), 256'({1'b1, EXP_REV}));

        // R9 out-of-range select
        bus_write(16'h002E, 8'h07);
        bus_write(16'h002F, 8'h20);
        bus_write(16'h002E, 8'h30);
        bus_write(16'h002F, 8'h01);
        bus_read(16'h002F, v, d);
        check("R9 out of range read", 256'({v, d}), 256'({1'b1, 8'h00}));
        check("R9 no alias", 256'(dev_active), 256'(16'h4000));

        // R1 alternate strap
        strap_alt = 1'b1;
        bus_write(16'h002E, 8'h61);
        bus_write(16'h004E, 8'h07);
        bus_write(16'h004F, 8'h05);
        bus_read(16'h004F, v, d);
        check("R1 alt data", 256'({v, d}), 256'({1'b1, 8'h05}));
        bus_read(16'h004E, v, d);
        check("R1 alt index", 256'({v, d}), 256'({1'b1, 8'h07}));
        bus_read(16'h002F, v, d);
        check("R1 primary silent", 256'({v, d}), 256'(0));

        // R11 reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 clears active", 256'(dev_active), 256'(0));
        check("R11 clears base", dev_base, '0);
        rst_n = 1'b1;
        bus_write(16'h004E, 8'h07);
        bus_read(16'h004F, v, d);
        check("R11 select cleared", 256'({v, d}), 256'({1'b1, 8'h00}));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule